// File: doc/BRIEF.md
# Byte-Wide Many-Time-Programmable Flash Model

This block is a synthesizable, clock-cycle model of a byte-wide flash array that is erased and rewritten only by an external programmer. It is driven by active-low chip-select, output-gate and write-strobe pins, an address bus and a data-in bus. Two flag inputs stand in for the raised programming voltage. One marks the output-gate pin at that voltage and the other marks address bit 9 at that voltage. The flags alone pick the operating mode; there is no command protocol.

With the output-gate flag set, a falling write strobe begins either a byte program or, when the address-9 flag is also set, a whole-array erase. Each operation takes a parameterised number of clock cycles, and `busy` is high for that time. A program can only clear bits, so the stored byte becomes the old byte AND the new byte. Only the erase returns bits to 1. If a required flag drops mid-operation, the operation is abandoned, the array is left untouched and a sticky error flag is raised. With the address-9 flag set alone, reads return identification codes instead of array data.

The control FSM has three states: `S_IDLE`, `S_PROG` and `S_ERASE`. Its transitions are: program start (`S_IDLE`→`S_PROG`), erase start (`S_IDLE`→`S_ERASE`), program commit or program abort (`S_PROG`→`S_IDLE`), and erase commit or erase abort (`S_ERASE`→`S_IDLE`).

Top module: `mtp_flash`

## Requirements
- R1: After reset every byte reads FFh, and `busy` and `err` are 0.
- R2: `dout_en` is 1 only while `ce_n`=0, `oe_n`=0 and `oe_hv`=0, and in that case `dout` is the byte at `addr` (same cycle). Otherwise `dout_en`=0 and `dout`=00h.
- R3: With `ce_n`=0, `oe_n`=0, `oe_hv`=0 and `a9_hv`=1, `dout` is BFh when `addr[0]`=0. When `addr[0]`=1 it is the device code for `DENSITY_SEL`: 0→C4h, 1→C5h, 2→C6h, 3→C2h.
- R4: A falling `we_n` seen by a clock edge while idle with `ce_n`=0, `oe_hv`=1 and `a9_hv`=0 starts a program of the `addr`/`din` present at that edge. `busy` is high for exactly `PROG_CYCLES` cycles starting at that edge.
- R5: A completed program stores old AND new at the latched address, so bits only go from 1 to 0.
- R6: A falling `we_n` while idle with `ce_n`=0, `oe_hv`=1 and `a9_hv`=1 starts an erase. `busy` is high for exactly `ERASE_CYCLES` cycles, then every byte is FFh. `addr` and `din` have no effect.
- R7: If `oe_hv` is 0 at an edge during a program, `busy` drops at that edge, `err` rises, and the target byte keeps its old value.
- R8: If `oe_hv` or `a9_hv` is 0 at an edge during an erase, `busy` drops at that edge, `err` rises, and the array is unchanged.
- R9: Falling `we_n` edges while `busy` is high are ignored.
- R10: Falling `we_n` edges with `ce_n`=1, or with `oe_hv`=0, start nothing and change no byte.
- R11: `err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads every byte with FFh |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low, falling edge starts an operation |
| oe_hv | input | 1 | Output-gate pin held at programming voltage |
| a9_hv | input | 1 | Address bit 9 held at programming voltage |
| addr | input | AW | Byte address, AW = clog2(DEPTH) |
| din | input | 8 | Byte to program |
| dout | output | 8 | Read data, 00h when not driven |
| dout_en | output | 1 | Drive enable for dout |
| busy | output | 1 | Program or erase in progress |
| err | output | 1 | Sticky abort flag |

## Verification
Reads and identification codes are combinational. The bench therefore samples them a short delay after changing the pins at a falling clock edge, with no clock edge in between. `busy` rises at the first rising edge that sees `we_n` low. It must read 1 at each of the next `PROG_CYCLES` (or `ERASE_CYCLES`) falling edges and 0 at the one after, and the bench checks every one of those falling edges. An abort is due at the first rising edge after the flag drops, so `busy`=0 and `err`=1 are checked at the falling edge that follows. Stored bytes are then read back in read mode once `busy` is low.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_READ,
        M_IDENT,
        M_PROG,
        M_ERASE
    } mode_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PROG,
        S_ERASE
    } op_state_t;

    localparam logic [7:0] MFR_CODE   = 8'hBF;
    localparam logic [7:0] BLANK_BYTE = 8'hFF;

    function automatic logic [7:0] dev_code(input int sel);
        case (sel)
            0:       return 8'hC4;
            1:       return 8'hC5;
            2:       return 8'hC6;
            default: return 8'hC2;
        endcase
    endfunction

endpackage

// File: rtl/mtp_mode_dec.sv
module mtp_mode_dec
    import mtp_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_hv,
    input  logic  a9_hv,
    output mode_t mode
);
    always_comb begin
        if (ce_n)
            mode = M_STANDBY;
        else if (oe_hv && a9_hv)
            mode = M_ERASE;
        else if (oe_hv)
            mode = M_PROG;
        else if (a9_hv)
            mode = M_IDENT;
        else
            mode = M_READ;
    end
endmodule

// File: rtl/mtp_op_timer.sv
module mtp_op_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/mtp_array.sv
module mtp_array
    import mtp_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          clr_all,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[i] <= BLANK_BYTE;
            else if (clr_all)
                mem[i] <= BLANK_BYTE;
            else if (wr_en && wr_addr == AW'(i))
                mem[i] <= mem[i] & wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mtp_flash.sv
module mtp_flash
    import mtp_pkg::*;
#(
    parameter int DEPTH        = 256,
    parameter int DENSITY_SEL  = 0,
    parameter int PROG_CYCLES  = 500,
    parameter int ERASE_CYCLES = 5000000,
    localparam int AW          = $clog2(DEPTH),
    localparam int MAXC        = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
    localparam int CW          = $clog2(MAXC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          oe_hv,
    input  logic          a9_hv,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic [7:0]    dout,
    output logic          dout_en,
    output logic          busy,
    output logic          err
);
    mode_t         mode;
    op_state_t     state, nstate;
    logic          we_q, we_fall;
    logic          t_load, t_done;
    logic [CW-1:0] t_val;
    logic [AW-1:0] lat_addr;
    logic [7:0]    lat_data;
    logic          abort, wr_en, clr_all;
    logic [7:0]    rd_data;

    mtp_mode_dec u_dec (
        .ce_n (ce_n),
        .oe_hv(oe_hv),
        .a9_hv(a9_hv),
        .mode (mode)
    );

    assign we_fall = we_q && !we_n;

    // next state
    always_comb begin
        nstate  = state;
        abort   = 1'b0;
        wr_en   = 1'b0;
        clr_all = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (we_fall && mode == M_PROG)
                    nstate = S_PROG;
                else if (we_fall && mode == M_ERASE)
                    nstate = S_ERASE;
            end
            S_PROG: begin
                if (!oe_hv) begin
                    nstate = S_IDLE;
                    abort  = 1'b1;
                end else if (t_done) begin
                    nstate = S_IDLE;
                    wr_en  = 1'b1;
                end
            end
            S_ERASE: begin
                if (!oe_hv || !a9_hv) begin
                    nstate = S_IDLE;
                    abort  = 1'b1;
                end else if (t_done) begin
                    nstate  = S_IDLE;
                    clr_all = 1'b1;
                end
            end
            default: nstate = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nstate;
    end

    assign t_load = (state == S_IDLE) && (nstate != S_IDLE);
    assign t_val  = (nstate == S_ERASE) ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);

    mtp_op_timer #(.CW(CW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .load_val(t_val),
        .run     (state != S_IDLE),
        .done    (t_done)
    );

    // registered outputs and latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q     <= 1'b1;
            err      <= 1'b0;
            lat_addr <= '0;
            lat_data <= BLANK_BYTE;
        end else begin
            we_q <= we_n;
            if (abort)
                err <= 1'b1;
            if (t_load) begin
                lat_addr <= addr;
                lat_data <= din;
            end
        end
    end

    mtp_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(lat_addr),
        .wr_data(lat_data),
        .clr_all(clr_all),
        .rd_addr(addr),
        .rd_data(rd_data)
    );

    // combinational outputs
    always_comb begin
        busy    = (state != S_IDLE);
        dout_en = !ce_n && !oe_n && !oe_hv;
        dout    = 8'h00;
        if (dout_en) begin
            if (mode == M_IDENT)
                dout = addr[0] ? dev_code(DENSITY_SEL) : MFR_CODE;
            else
                dout = rd_data;
        end
    end
endmodule

// File: rtl/mtp_flash_chk.sv
module mtp_flash_chk #(
    parameter int AW   = 8,
    parameter int MAXC = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          oe_hv,
    input logic          a9_hv,
    input logic [AW-1:0] addr,
    input logic [7:0]    dout,
    input logic          dout_en,
    input logic          busy,
    input logic          err
);
    logic [31:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_len <= '0;
        else if (busy)
            run_len <= run_len + 1;
        else
            run_len <= '0;
    end

    assert_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (!dout_en && dout == 8'h00));

    assert_mfr_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !oe_hv && a9_hv && !addr[0]) |-> (dout_en && dout == 8'hBF));

    assert_prog_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(we_n) && !busy && !ce_n && oe_hv) |=> busy);

    assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= MAXC);

    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !oe_hv) |=> (!busy && err));

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

bind mtp_flash mtp_flash_chk #(.AW(AW), .MAXC(MAXC)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .oe_hv  (oe_hv),
    .a9_hv  (a9_hv),
    .addr   (addr),
    .dout   (dout),
    .dout_en(dout_en),
    .busy   (busy),
    .err    (err)
);

// File: tb/sim_mtp_flash.sv
module sim_mtp_flash;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);
    localparam int PC    = 4;
    localparam int EC    = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, oe_hv = 1'b0, a9_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en, busy, err;

    int nchk = 0, nfail = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    mtp_flash #(.DEPTH(DEPTH), .DENSITY_SEL(1), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .oe_hv(oe_hv), .a9_hv(a9_hv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .busy(busy), .err(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_pins();
        @(negedge clk);
        ce_n = 1; oe_n = 1; we_n = 1; oe_hv = 0; a9_hv = 0;
    endtask

    task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        @(negedge clk);
        ce_n = 0; oe_n = 0; oe_hv = 0; a9_hv = 0; we_n = 1; addr = a;
        #2;
        chk(req, {23'd0, dout_en, dout}, {23'd0, 1'b1, exp});
    endtask

    task automatic start_op(input bit erase, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 0; oe_n = 1; oe_hv = 1; a9_hv = erase; addr = a; din = d; we_n = 0;
    endtask

    task automatic timed_op(input string req, input bit erase, input logic [AW-1:0] a,
                            input logic [7:0] d, input int n);
        start_op(erase, a, d);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (i == 1) begin we_n = 1; addr = ~a; din = 8'h00; end
            chk(req, busy, 1);
        end
        @(negedge clk);
        chk(req, busy, 0);
        idle_pins();
    endtask

    task automatic t_reset();
        chk("R1", {busy, err}, 0);
        read_chk("R1", 0, 8'hFF);
        read_chk("R1", AW'(DEPTH - 1), 8'hFF);
    endtask

    task automatic t_output_gate();
        @(negedge clk); ce_n = 1; oe_n = 0; oe_hv = 0; #2;
        chk("R2", {dout_en, dout}, 0);
        @(negedge clk); ce_n = 0; oe_n = 1; #2;
        chk("R2", {dout_en, dout}, 0);
        @(negedge clk); ce_n = 0; oe_n = 0; oe_hv = 1; #2;
        chk("R2", {dout_en, dout}, 0);
        idle_pins();
    endtask

    task automatic t_ident();
        @(negedge clk); ce_n = 0; oe_n = 0; oe_hv = 0; a9_hv = 1; addr = 0; #2;
        chk("R3", {dout_en, dout}, {1'b1, 8'hBF});
        @(negedge clk); addr = 1; #2;
        chk("R3", {dout_en, dout}, {1'b1, 8'hC5});
        idle_pins();
    endtask

    task automatic t_program();
        timed_op("R4", 0, 3, 8'hA5, PC);
        read_chk("R4", 3, 8'hA5);
        timed_op("R5", 0, 3, 8'h0F, PC);
        read_chk("R5", 3, 8'h05);
        read_chk("R5", 4, 8'hFF);
    endtask

    task automatic t_busy_ignore();
        start_op(0, 7, 8'h00);
        @(negedge clk); we_n = 1;
        @(negedge clk); addr = 8; din = 8'h00; we_n = 0;
        @(negedge clk); we_n = 1;
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
        chk("R9", busy, 0);
        idle_pins();
        read_chk("R9", 7, 8'h00);
        read_chk("R9", 8, 8'hFF);
    endtask

    task automatic t_no_start();
        @(negedge clk); ce_n = 1; oe_hv = 1; addr = 3; din = 8'h00; we_n = 0;
        @(negedge clk); chk("R10", busy, 0); we_n = 1;
        @(negedge clk); ce_n = 0; oe_hv = 0; oe_n = 1; we_n = 0;
        @(negedge clk); chk("R10", busy, 0); we_n = 1;
        @(negedge clk); a9_hv = 1; we_n = 0;
        @(negedge clk); chk("R10", busy, 0);
        idle_pins();
        read_chk("R10", 3, 8'h05);
    endtask

    task automatic t_prog_abort();
        start_op(0, 10, 8'h00);
        @(negedge clk); we_n = 1;
        @(negedge clk); oe_hv = 0;
        @(negedge clk);
        chk("R7", {busy, err}, {1'b0, 1'b1});
        idle_pins();
        read_chk("R7", 10, 8'hFF);
        repeat (5) @(negedge clk);
        chk("R11", err, 1);
    endtask

    task automatic t_erase_abort();
        start_op(1, 0, 8'h00);
        @(negedge clk); we_n = 1;
        @(negedge clk); a9_hv = 0;
        @(negedge clk);
        chk("R8", {busy, err}, {1'b0, 1'b1});
        idle_pins();
        read_chk("R8", 3, 8'h05);
    endtask

    task automatic t_erase();
        timed_op("R6", 1, 5, 8'h00, EC);
        read_chk("R6", 3, 8'hFF);
        read_chk("R6", 7, 8'hFF);
        read_chk("R6", 5, 8'hFF);
    endtask

    task automatic t_rereset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R11", err, 0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_output_gate();
        t_ident();
        t_program();
        t_busy_ignore();
        t_no_start();
        t_prog_abort();
        t_erase_abort();
        t_erase();
        t_rereset();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule